// File: doc/BRIEF.md
# Six-State JK Sequence Counter

A synchronous counter that walks a fixed, repeating loop of six 3-bit codes. The three stages (A as the most significant bit, then B, then C) are JK flip-flops sharing one clock. Their J and K inputs come from fixed excitation equations. These equations skip codes 011 and 111, so the counter does not follow plain binary order. A control block in front of the stages steers J and K for reset, load and hold. The flip-flops themselves stay pure JK cells.

A one-cycle wrap flag marks the step that closes the loop. A parallel load port lets the state be placed on any code, including the two codes outside the loop. The equations bring either of those codes back into the loop within one enabled step.

Top module: `seq6_jk_counter`

## Requirements
- R1: With enable high and no reset or load, the state `q_o` (bit 2 = A, bit 0 = C) advances one step per clock along 000 → 001 → 010 → 100 → 101 → 110 → 000 and repeats forever.
- R2: A synchronous reset sets `q_o` to 000 on the next clock. Reset overrides both load and enable.
- R3: With enable low and no reset or load, `q_o` keeps its value across the clock.
- R4: A load (when reset is low) places `ld_val` on `q_o` at the next clock, whether enable is high or low.
- R5: An enabled step from the unused code 011 leads to 100.
- R6: An enabled step from the unused code 111 leads to 000.
- R7: `wrap_o` is 1 exactly while `q_o` is 110, enable is high, and neither reset nor load is active. It is 0 in every other case, including the step from 111 to 000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by all three stages |
| rst | input | 1 | Synchronous reset, active high |
| cnt_en | input | 1 | Advance the sequence on this clock |
| ld_en | input | 1 | Parallel load of `ld_val` on this clock |
| ld_val | input | 3 | Code to load (bit 2 = A) |
| q_o | output | 3 | Counter state A,B,C |
| wrap_o | output | 1 | The current enabled step closes the loop (110 to 000) |

## Verification
The unused codes 011 and 111 never show up in normal counting, so recovery cannot be reached by counting alone. The bench loads each of these codes directly, takes one enabled step, and checks the landing code and that `wrap_o` stays low. The bench also loads every code with enable low, which shows that a load does not depend on enable. Reset is applied together with a load to check its priority.

// File: rtl/seq6_jk_counter.sv
module jk_stage (
  input  logic clk,
  input  logic j,
  input  logic k,
  output logic q
);
  always_ff @(posedge clk) begin
    case ({j, k})
      2'b00: q <= q;
      2'b01: q <= 1'b0;
      2'b10: q <= 1'b1;
      default: q <= ~q;
    endcase
  end
endmodule

module seq6_jk_counter (
  input  logic       clk,
  input  logic       rst,
  input  logic       cnt_en,
  input  logic       ld_en,
  input  logic [2:0] ld_val,
  output logic [2:0] q_o,
  output logic       wrap_o
);
  logic [2:0] q, j, k, j_seq, k_seq;

  // Excitation: A: J=K=B ; B: J=C, K=1 ; C: J=~B, K=1
  assign j_seq = {q[1], q[0], ~q[1]};
  assign k_seq = {q[1], 1'b1, 1'b1};

  always_comb begin
    if (rst) begin
      j = 3'b000; k = 3'b111;
    end else if (ld_en) begin
      j = ld_val; k = ~ld_val;
    end else if (cnt_en) begin
      j = j_seq;  k = k_seq;
    end else begin
      j = 3'b000; k = 3'b000;
    end
  end

  for (genvar s = 0; s < 3; s++) begin : g_stage
    jk_stage u_ff (.clk(clk), .j(j[s]), .k(k[s]), .q(q[s]));
  end

  assign q_o    = q;
  assign wrap_o = cnt_en & ~rst & ~ld_en & (q == 3'b110);
endmodule

// File: rtl/seq6_jk_counter_chk.sv
module seq6_jk_counter_chk (
  input logic       clk,
  input logic       rst,
  input logic       cnt_en,
  input logic       ld_en,
  input logic [2:0] ld_val,
  input logic [2:0] q_o,
  input logic       wrap_o
);
  logic run;
  assign run = cnt_en & ~ld_en;

  p_reset_zero_r2: assert property (@(posedge clk) rst |=> q_o == 3'b000);

  p_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (!ld_en && !cnt_en) |=> $stable(q_o));

  p_load_r4: assert property (@(posedge clk) disable iff (rst)
    ld_en |=> q_o == $past(ld_val));

  p_stay_legal_r1: assert property (@(posedge clk) disable iff (rst)
    (run && q_o != 3'b011 && q_o != 3'b111) |=> (q_o != 3'b011 && q_o != 3'b111));

  p_recover_011_r5: assert property (@(posedge clk) disable iff (rst)
    (run && q_o == 3'b011) |=> q_o == 3'b100);

  p_recover_111_r6: assert property (@(posedge clk) disable iff (rst)
    (run && q_o == 3'b111) |=> q_o == 3'b000);

  p_wrap_lands_r7: assert property (@(posedge clk) disable iff (rst)
    wrap_o |=> q_o == 3'b000);

  p_wrap_quiet_r7: assert property (@(posedge clk) disable iff (rst)
    (!cnt_en || ld_en) |-> !wrap_o);
endmodule

bind seq6_jk_counter seq6_jk_counter_chk u_chk (
  .clk(clk), .rst(rst), .cnt_en(cnt_en), .ld_en(ld_en),
  .ld_val(ld_val), .q_o(q_o), .wrap_o(wrap_o)
);

// File: tb/tb_seq6_jk_counter.sv
module tb_seq6_jk_counter;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cnt_en = 1'b0;
  logic       ld_en = 1'b0;
  logic [2:0] ld_val = 3'b000;
  logic [2:0] q_o;
  logic       wrap_o;

  int n_run = 0;
  int n_fail = 0;
  int ref_q = 0;
  int order[$] = '{0, 1, 2, 4, 5, 6};

  always #(CLK_PERIOD/2) clk = ~clk;

  seq6_jk_counter dut (
    .clk(clk), .rst(rst), .cnt_en(cnt_en), .ld_en(ld_en),
    .ld_val(ld_val), .q_o(q_o), .wrap_o(wrap_o)
  );

  function automatic int ref_next(int cur);
    if (cur == 3) return 4;
    if (cur == 7) return 0;
    foreach (order[i]) if (order[i] == cur) return order[(i + 1) % order.size()];
    return 0;
  endfunction

  task automatic check(string tag, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Inputs applied after a negedge; wrap checked before the edge, state after.
  task automatic step(bit r, bit e, bit l, int v, string tag);
    int exp_wrap;
    rst = r; cnt_en = e; ld_en = l; ld_val = 3'(v);
    #1;
    exp_wrap = (e && !r && !l && ref_q == 6) ? 1 : 0;
    check({tag, "/R7 wrap"}, int'(wrap_o), exp_wrap);
    @(posedge clk);
    if (r) ref_q = 0;
    else if (l) ref_q = v;
    else if (e) ref_q = ref_next(ref_q);
    @(negedge clk);
    check({tag, " state"}, int'(q_o), ref_q);
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    @(negedge clk);
    step(1, 0, 0, 0, "R2 reset");
    check("R2 reset value", int'(q_o), 0);

    for (int i = 0; i < 20; i++) step(0, 1, 0, 0, "R1 run");

    for (int i = 0; i < 16; i++) step(0, (i % 3) != 0, 0, 0, "R3 gated run");
    for (int i = 0; i < 4; i++) step(0, 0, 0, 0, "R3 hold");

    for (int c = 0; c < 8; c++) begin
      step(0, 0, 1, c, "R4 load en low");
      step(0, 0, 0, 0, "R3 hold after load");
      step(0, 1, 1, 7 - c, "R4 load en high");
    end

    step(0, 0, 1, 3, "R4 load 011");
    step(0, 1, 0, 0, "R5 recover 011");
    check("R5 lands 100", int'(q_o), 4);

    step(0, 0, 1, 7, "R4 load 111");
    step(0, 1, 0, 0, "R6 recover 111");
    check("R6 lands 000", int'(q_o), 0);

    step(0, 0, 1, 6, "R4 load 110");
    step(0, 0, 0, 0, "R7 no wrap when held");
    step(0, 1, 1, 6, "R7 no wrap under load");
    step(0, 1, 0, 0, "R7 wrap step");

    for (int i = 0; i < 3; i++) step(0, 1, 0, 0, "R1 run");
    step(1, 1, 1, 5, "R2 reset over load");
    step(0, 0, 1, 6, "R4 load 110");
    step(1, 1, 0, 0, "R2 reset over wrap");
    for (int i = 0; i < 8; i++) step(0, 1, 0, 0, "R1 after reset");

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule